// File: doc/BRIEF.md
# Serial Receiver Status Flags and Interrupt Logic

This block sits beside the receive shifter of an asynchronous serial port and holds everything software sees of the receive path. The shifter hands over each finished character together with a noise indication, reports a busy level while a frame is on the wire, and strobes one sample of the line per bit time. From these inputs the block keeps the receive data register and four event flags: data-full, idle-line, overrun and noise. It also implements the receiver sleep state, including waking on an idle line.

Two interrupt outputs are built from the flags. The receiver interrupt covers data-full and idle. The error interrupt covers overrun and noise. Each flag has its own enable input. Software reads status and data through a small read port. Flags are cleared by reading the status register and then the data register.

Top module: `rx_status_irq`

## Requirements
- R1: After reset every flag, the sleep state and both interrupt outputs are 0, and the data register reads 0x000.
- R2: A completed character that arrives while data-full is clear and the receiver is awake is loaded into the data register, and data-full is set.
- R3: A character that completes while data-full is still set sets the overrun flag. The data register keeps the earlier character and the new one is lost.
- R4: A completed character that is reported with noise sets the noise flag.
- R5: `irq_rx` equals, one clock later, (data-full AND `en_full`) OR (idle AND `en_idle`). It stays high until every enabled source is cleared.
- R6: `irq_err` equals, one clock later, (overrun AND `en_overrun`) OR (noise AND `en_noise`).
- R7: A read with `rd_sel`=1 clears exactly the flags that were set at the most recent earlier read with `rd_sel`=0. A data read with no status read before it clears nothing. The status word has data-full at bit 0, idle at bit 1, overrun at bit 2, noise at bit 3 and sleep at bit 4; all other bits are 0.
- R8: Idle is detected after 10 consecutive logic-1 bit samples when `cfg_long_frame`=0, and after 11 when it is 1. Any logic-0 sample restarts the count.
- R9: With `cfg_idle_after_stop`=1, logic-1 samples taken while `rx_busy` is high do not count towards idle. With it at 0, the data bits and the stop bit of a frame do count.
- R10: The idle flag sets once per idle period. After it sets, it cannot set again until a new character has been accepted.
- R11: A pulse on `sleep_wr` loads `sleep_wdata` into the sleep state. While asleep, completed characters are ignored: no flag changes and the data register is unchanged. With `cfg_wake_idle`=1 the receiver leaves sleep as soon as idle is detected. If the line is already idle when sleep is written, it wakes on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_done | input | 1 | One-cycle pulse: the shifter finished a character |
| char_data | input | DATA_W | Character delivered with `char_done` |
| char_noise | input | 1 | Noise was seen on some bit of that character |
| bit_tick | input | 1 | One-cycle strobe, once per bit time |
| line_bit | input | 1 | Line sample valid with `bit_tick` |
| rx_busy | input | 1 | High from the start bit through the stop bit |
| cfg_long_frame | input | 1 | 1 selects 9-bit data frames (11-bit idle count) |
| cfg_idle_after_stop | input | 1 | 1 starts idle counting only after the stop bit |
| cfg_wake_idle | input | 1 | 1 makes an idle line wake the sleeping receiver |
| en_full | input | 1 | Data-full interrupt enable |
| en_idle | input | 1 | Idle interrupt enable |
| en_overrun | input | 1 | Overrun interrupt enable |
| en_noise | input | 1 | Noise interrupt enable |
| sleep_wr | input | 1 | Write strobe for the sleep state |
| sleep_wdata | input | 1 | Value written to the sleep state |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 reads status, 1 reads data |
| rd_data | output | DATA_W | Read data, combinational |
| irq_rx | output | 1 | Receiver interrupt |
| irq_err | output | 1 | Error interrupt |
| rx_asleep | output | 1 | Sleep state |

## Verification
The bench sends frames whose last data bits are ones and checks whether those bits count towards idle under each idle-type setting. A design with the idle type inverted or ignored flags idle five bit times too early or too late. It checks the count boundary one sample either side of 10 and 11, and it inserts a zero in the middle of an idle stretch: a counter that does not restart on that zero flags idle early. It reads data without a status read first, to catch a clear that skips the two-step sequence. It sends a second character into a full register, to catch an overrun that replaces the stored byte. It writes sleep while the line is already idle, and a design that ignores that case stays asleep.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
    localparam int unsigned FLG_N     = 4;
    localparam int unsigned IDX_FULL  = 0;
    localparam int unsigned IDX_IDLE  = 1;
    localparam int unsigned IDX_OVR   = 2;
    localparam int unsigned IDX_NOISE = 3;
    localparam int unsigned IDX_SLEEP = 4;
endpackage

// File: rtl/rx_idle_counter.sv
module rx_idle_counter #(
    parameter int SHORT_LEN = 10,
    parameter int LONG_LEN  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic line_bit,
    input  logic rx_busy,
    input  logic after_stop,
    input  logic long_frame,
    output logic idle_now
);
    localparam int CNT_W = $clog2(LONG_LEN + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        limit = long_frame ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
        cnt_d = cnt_q;
        if (bit_tick) begin
            if (!line_bit || (after_stop && rx_busy)) begin
                cnt_d = '0;
            end else if (cnt_q < limit) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
        idle_now = (cnt_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rx_irq_merge.sv
module rx_irq_merge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] en,
    output logic         irq
);
    logic irq_d, irq_q;

    always_comb irq_d = |(flags & en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;
endmodule

// File: rtl/rx_status_irq.sv
module rx_status_irq
    import rx_stat_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int SHORT_LEN = 10,
    parameter int LONG_LEN  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_noise,
    input  logic              bit_tick,
    input  logic              line_bit,
    input  logic              rx_busy,
    input  logic              cfg_long_frame,
    input  logic              cfg_idle_after_stop,
    input  logic              cfg_wake_idle,
    input  logic              en_full,
    input  logic              en_idle,
    input  logic              en_overrun,
    input  logic              en_noise,
    input  logic              sleep_wr,
    input  logic              sleep_wdata,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_rx,
    output logic              irq_err,
    output logic              rx_asleep
);
    localparam int STAT_W = IDX_SLEEP + 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [FLG_N-1:0]  flags;
        logic [FLG_N-1:0]  seen;
        logic              armed;
        logic              asleep;
    } state_t;

    state_t st_d, st_q;
    logic   idle_now;
    logic   stat_rd, data_rd, accept;
    logic [STAT_W-1:0] stat_word;
    logic [FLG_N-1:0]  flag_vec;
    logic [DATA_W-1:0] data_vec;

    rx_idle_counter #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .line_bit   (line_bit),
        .rx_busy    (rx_busy),
        .after_stop (cfg_idle_after_stop),
        .long_frame (cfg_long_frame),
        .idle_now   (idle_now)
    );

    always_comb begin
        stat_rd = rd_en && !rd_sel;
        data_rd = rd_en && rd_sel;
        accept  = char_done && !st_q.asleep;
        st_d    = st_q;

        // two-step clear: data read removes what the status read saw
        if (data_rd) begin
            st_d.flags = st_q.flags & ~st_q.seen;
            st_d.seen  = '0;
        end
        if (stat_rd) st_d.seen = st_q.flags;

        if (idle_now && st_q.armed && !st_q.flags[IDX_IDLE]) begin
            st_d.flags[IDX_IDLE] = 1'b1;
            st_d.armed           = 1'b0;
        end

        if (accept) begin
            if (st_d.flags[IDX_FULL]) begin
                st_d.flags[IDX_OVR] = 1'b1;
            end else begin
                st_d.data            = char_data;
                st_d.flags[IDX_FULL] = 1'b1;
            end
            if (char_noise) st_d.flags[IDX_NOISE] = 1'b1;
            st_d.armed = 1'b1;
        end

        if (sleep_wr) begin
            st_d.asleep = sleep_wdata;
        end else if (st_q.asleep && cfg_wake_idle && idle_now) begin
            st_d.asleep = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rx_irq_merge #(.N(2)) u_irq_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .flags ({st_q.flags[IDX_IDLE], st_q.flags[IDX_FULL]}),
        .en    ({en_idle, en_full}),
        .irq   (irq_rx)
    );

    rx_irq_merge #(.N(2)) u_irq_err (
        .clk   (clk),
        .rst_n (rst_n),
        .flags ({st_q.flags[IDX_NOISE], st_q.flags[IDX_OVR]}),
        .en    ({en_noise, en_overrun}),
        .irq   (irq_err)
    );

    assign stat_word = {st_q.asleep, st_q.flags};
    assign rd_data   = rd_sel ? st_q.data : DATA_W'(stat_word);
    assign rx_asleep = st_q.asleep;
    assign flag_vec  = st_q.flags;
    assign data_vec  = st_q.data;
endmodule

// File: rtl/rx_status_irq_chk.sv
module rx_status_irq_chk
    import rx_stat_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              char_done,
    input logic              en_full,
    input logic              en_overrun,
    input logic              irq_rx,
    input logic              irq_err,
    input logic              rx_asleep,
    input logic              idle_now,
    input logic [FLG_N-1:0]  flags,
    input logic [DATA_W-1:0] data_reg
);
    // R3: overrun never coincides with a data register update
    assert_overrun_keeps_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[IDX_OVR]) |-> $stable(data_reg));

    // R5: enabled data-full drives the receiver interrupt on the next cycle
    assert_full_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[IDX_FULL] && en_full) |=> irq_rx);

    // R6: enabled overrun drives the error interrupt on the next cycle
    assert_overrun_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[IDX_OVR] && en_overrun) |=> irq_err);

    // R8: the idle flag only rises after the counter reported idle
    assert_idle_from_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[IDX_IDLE]) |-> $past(idle_now));

    // R11: a character arriving in sleep leaves the data register alone
    assert_sleep_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_asleep && char_done) |=> $stable(data_reg));
endmodule

bind rx_status_irq rx_status_irq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_done  (char_done),
    .en_full    (en_full),
    .en_overrun (en_overrun),
    .irq_rx     (irq_rx),
    .irq_err    (irq_err),
    .rx_asleep  (rx_asleep),
    .idle_now   (idle_now),
    .flags      (flag_vec),
    .data_reg   (data_vec)
);

// File: tb/rx_status_irq_test.sv
`timescale 1ns/1ps
module rx_status_irq_test;
    localparam int DATA_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic char_done = 0, char_noise = 0, bit_tick = 0, line_bit = 1, rx_busy = 0;
    logic [DATA_W-1:0] char_data = '0;
    logic cfg_long_frame = 0, cfg_idle_after_stop = 0, cfg_wake_idle = 0;
    logic en_full = 0, en_idle = 0, en_overrun = 0, en_noise = 0;
    logic sleep_wr = 0, sleep_wdata = 0, rd_en = 0, rd_sel = 0;
    logic [DATA_W-1:0] rd_data;
    logic irq_rx, irq_err, rx_asleep;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rx_status_irq #(.DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
        .char_noise(char_noise), .bit_tick(bit_tick), .line_bit(line_bit),
        .rx_busy(rx_busy), .cfg_long_frame(cfg_long_frame),
        .cfg_idle_after_stop(cfg_idle_after_stop), .cfg_wake_idle(cfg_wake_idle),
        .en_full(en_full), .en_idle(en_idle), .en_overrun(en_overrun),
        .en_noise(en_noise), .sleep_wr(sleep_wr), .sleep_wdata(sleep_wdata),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq_rx(irq_rx),
        .irq_err(irq_err), .rx_asleep(rx_asleep)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic sel, output int val);
        rd_en = 1'b1; rd_sel = sel;
        #1 val = int'(rd_data);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_char(input int d, input logic nz);
        char_done = 1'b1; char_data = DATA_W'(d); char_noise = nz;
        @(negedge clk);
        char_done = 1'b0; char_noise = 1'b0;
    endtask

    task automatic tick(input logic b, input logic busy);
        bit_tick = 1'b1; line_bit = b; rx_busy = busy;
        @(negedge clk);
        bit_tick = 1'b0; line_bit = 1'b1; rx_busy = 1'b0;
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b0);
    endtask

    task automatic frame(input int d);
        tick(1'b0, 1'b1);
        for (int i = 0; i < 8; i++) tick(d[i], 1'b1);
        tick(1'b1, 1'b1);
        send_char(d, 1'b0);
    endtask

    task automatic clear_all();
        int v;
        rd(1'b0, v);
        rd(1'b1, v);
    endtask

    task automatic t_reset();
        int v;
        rd(1'b0, v); chk("R1 status", v, 0);
        rd(1'b1, v); chk("R1 data", v, 0);
        chk("R1 irq_rx", irq_rx, 0);
        chk("R1 irq_err", irq_err, 0);
        chk("R1 asleep", rx_asleep, 0);
    endtask

    task automatic t_basic();
        int v;
        send_char(9'h0A5, 1'b0);
        step(2);
        chk("R5 irq_rx masked", irq_rx, 0);
        rd(1'b1, v); chk("R2 data", v, 'h0A5);
        rd(1'b0, v); chk("R7 data read alone keeps full", v, 'h01);
        en_full = 1'b1; step(2);
        chk("R5 irq_rx enabled", irq_rx, 1);
        rd(1'b1, v); step(2);
        rd(1'b0, v); chk("R7 cleared", v, 0);
        chk("R5 irq_rx drops", irq_rx, 0);
        en_full = 1'b0;
    endtask

    task automatic t_overrun();
        int v;
        send_char(9'h011, 1'b0);
        send_char(9'h022, 1'b0);
        step(2);
        rd(1'b1, v); chk("R3 old char kept", v, 'h011);
        rd(1'b0, v); chk("R3 overrun flag", v, 'h05);
        chk("R6 irq_err masked", irq_err, 0);
        en_overrun = 1'b1; step(2);
        chk("R6 irq_err overrun", irq_err, 1);
        rd(1'b1, v); step(2);
        chk("R6 irq_err cleared", irq_err, 0);
        rd(1'b0, v); chk("R7 overrun cleared", v, 0);
        en_overrun = 1'b0;
    endtask

    task automatic t_noise();
        int v;
        send_char(9'h13C, 1'b1);
        step(1);
        rd(1'b0, v); chk("R4 noise flag", v, 'h09);
        en_noise = 1'b1; step(2);
        chk("R6 irq_err noise", irq_err, 1);
        rd(1'b1, v); chk("R2 nine-bit data", v, 'h13C);
        step(2);
        chk("R6 irq_err noise cleared", irq_err, 0);
        en_noise = 1'b0;
    endtask

    task automatic t_idle();
        int v;
        en_idle = 1'b1;
        cfg_idle_after_stop = 1'b0;
        frame('hF0);
        clear_all();
        ones(4); step(2);
        rd(1'b0, v); chk("R9 from start bit, 9 ones", v, 0);
        ones(1); step(2);
        rd(1'b0, v); chk("R9 from start bit, 10 ones", v, 'h02);
        chk("R5 irq_rx idle", irq_rx, 1);
        rd(1'b1, v); step(2);
        chk("R5 irq_rx idle cleared", irq_rx, 0);
        ones(12); step(2);
        rd(1'b0, v); chk("R10 no second idle", v, 0);

        cfg_idle_after_stop = 1'b1;
        frame('hF0);
        clear_all();
        ones(9); step(2);
        rd(1'b0, v); chk("R9 after stop, 9 ones", v, 0);
        ones(1); step(2);
        rd(1'b0, v); chk("R8 short count 10", v, 'h02);
        rd(1'b1, v);

        cfg_long_frame = 1'b1;
        frame('hF0);
        clear_all();
        ones(6); tick(1'b0, 1'b0); ones(10); step(2);
        rd(1'b0, v); chk("R8 restart and long 10", v, 0);
        ones(1); step(2);
        rd(1'b0, v); chk("R8 long count 11", v, 'h02);
        rd(1'b1, v);
        en_idle = 1'b0;
    endtask

    task automatic t_sleep();
        int v;
        cfg_wake_idle = 1'b1;
        sleep_wr = 1'b1; sleep_wdata = 1'b1;
        @(negedge clk); sleep_wr = 1'b0;
        chk("R11 sleep written", rx_asleep, 1);
        step(1);
        chk("R11 immediate wake", rx_asleep, 0);

        cfg_wake_idle = 1'b0;
        sleep_wr = 1'b1; sleep_wdata = 1'b1;
        @(negedge clk); sleep_wr = 1'b0;
        step(2);
        chk("R11 stays asleep", rx_asleep, 1);
        send_char(9'h055, 1'b0); step(1);
        rd(1'b0, v); chk("R11 char ignored status", v, 'h10);
        rd(1'b1, v); chk("R11 char ignored data", v, 'h0F0);
        sleep_wr = 1'b1; sleep_wdata = 1'b0;
        @(negedge clk); sleep_wr = 1'b0;
        chk("R11 written awake", rx_asleep, 0);

        cfg_wake_idle = 1'b1;
        tick(1'b0, 1'b0);
        sleep_wr = 1'b1; sleep_wdata = 1'b1;
        @(negedge clk); sleep_wr = 1'b0;
        ones(10); step(2);
        chk("R11 asleep before idle", rx_asleep, 1);
        ones(1); step(2);
        chk("R11 wake on idle", rx_asleep, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_basic();
        t_overrun();
        t_noise();
        t_idle();
        t_sleep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule